// File: doc/BRIEF.md
# Post-Flag Dominant Run Monitor

This block watches the bus once a node has finished sending an error flag or an overload flag. Starting with the first bit after the flag, it counts consecutive dominant bits on the sampled bus. When the run grows past the tolerated length it raises an add-8 penalty request. The request goes to the transmit error counter if the node is currently the transmitter, or to the receive error counter if it is a receiver. The first recessive bit ends the watch.

How long a run is tolerated depends on which flag came before it. After an active error flag or an overload flag, the first penalty falls on the 14th dominant bit. After a passive error flag, it falls on the 8th. Every further 8 dominant bits bring another penalty. Separately, a receiver that sees a dominant level on the very first bit after its flag gets its own add-8 request.

The flag generator pulses `flag_end_i` in the cycle the flag finishes, with the flag kind alongside. The bit timing logic supplies `bit_stb_i` together with the sampled level. All outputs are combinational, one-cycle pulses. Each appears during the same strobe cycle as the bit that causes it, so the counter unit can take it at that clock edge.

Top module: `can_flag_dom_monitor`

## Requirements
- R1: While rst_ni is low, and after reset until the first flag end, all three outputs stay low, whatever the strobe and bus inputs do.
- R2: flag_kind_i = 2'b00 means an active error flag, 2'b10 an overload flag and 2'b11 is handled like 2'b00. After any of these, counting the first bit after the flag as bit 1, the first penalty pulse comes on the strobe of the 14th consecutive dominant bit, and no penalty comes on bits 1 to 13.
- R3: flag_kind_i = 2'b01 means a passive error flag. After it, the first penalty pulse comes on the strobe of the 8th consecutive dominant bit, and none comes on bits 1 to 7.
- R4: After the first penalty, a further penalty pulse comes on every 8th additional consecutive dominant bit (bits 22, 30, and so on after an active or overload flag; bits 16, 24, and so on after a passive flag), with no pulses in between.
- R5: A penalty appears on tx_pen_o when role_tx_i = 1 and on rx_pen_o when role_tx_i = 0, using the role in that strobe cycle. The two are never high together.
- R6: rx_first_dom_o pulses on the strobe of the first bit after a flag when that bit is dominant (bus_dom_i = 1) and role_tx_i = 0. It never pulses for a transmitter, and never on any later bit.
- R7: A strobe with bus_dom_i = 0 during monitoring ends it. Dominant bits after that produce no pulses until the next flag end.
- R8: Only cycles with bit_stb_i = 1 advance the count, and all outputs are low in every cycle without a strobe.
- R9: A flag end restarts monitoring from zero with the new flag kind, even in the middle of a run. A strobe in the same cycle as the flag end is not counted, and no output pulses in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_stb_i | input | 1 | One-cycle strobe per sampled bus bit |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant |
| flag_end_i | input | 1 | Pulse: the error flag or overload flag has just finished |
| flag_kind_i | input | 2 | Flag kind, valid with flag_end_i (00 active, 01 passive, 10 overload) |
| role_tx_i | input | 1 | 1 = node is transmitter, 0 = receiver |
| tx_pen_o | output | 1 | Add-8 request for the transmit error counter |
| rx_pen_o | output | 1 | Add-8 request for the receive error counter |
| rx_first_dom_o | output | 1 | Add-8 request: receiver saw a dominant first bit after its flag |

## Verification
The hardest case to reach from the ports is a long unbroken dominant run that reaches the repeat penalties (bit 22 and beyond, or bit 16 and beyond after a passive flag). Such a run has to be mixed with idle cycles, role changes and a flag end arriving mid-run. Purely random bus levels almost never produce one. The stimulus therefore picks a run length per episode, holds the bus dominant for that many strobes, and scatters non-strobe cycles with random bus levels between them. It then closes with a recessive bit and a few trailing dominant bits. Directed runs cover the exact thresholds and a restart by a flag end in the same cycle as a strobe.

// File: rtl/can_fdm_pkg.sv
package can_fdm_pkg;
  typedef enum logic [1:0] {
    FK_ACTIVE   = 2'b00,
    FK_PASSIVE  = 2'b01,
    FK_OVERLOAD = 2'b10,
    FK_RSVD     = 2'b11
  } flag_kind_e;
endpackage

// File: rtl/can_fdm_arm.sv
module can_fdm_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_stb_i,
  input  logic bus_dom_i,
  output logic step_o,
  output logic first_dom_o
);
  logic armed_q, first_q;
  logic live_bit;

  assign live_bit    = bit_stb_i && armed_q && !start_i;
  assign step_o      = live_bit && bus_dom_i;
  assign first_dom_o = step_o && first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      first_q <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      first_q <= 1'b1;
    end else if (live_bit) begin
      first_q <= 1'b0;
      if (!bus_dom_i) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/can_fdm_run_ctr.sv
module can_fdm_run_ctr #(
  parameter int unsigned ACT_LIMIT = 14,
  parameter int unsigned PAS_LIMIT = 8,
  parameter int unsigned REPEAT    = 8,
  parameter int unsigned CNT_W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic passive_i,
  input  logic step_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] ACT_T = CNT_W'(ACT_LIMIT);
  localparam logic [CNT_W-1:0] PAS_T = CNT_W'(PAS_LIMIT);
  localparam logic [CNT_W-1:0] REP_T = CNT_W'(REPEAT);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, target;
  logic             post_q, pas_q;

  // before the first penalty the limit follows the flag kind, afterwards the repeat span
  assign target  = post_q ? REP_T : (pas_q ? PAS_T : ACT_T);
  assign cnt_nxt = cnt_q + 1'b1;
  assign hit_o   = step_i && (cnt_nxt == target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      post_q <= 1'b0;
      pas_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      post_q <= 1'b0;
      pas_q  <= passive_i;
    end else if (step_i) begin
      if (hit_o) begin
        cnt_q  <= '0;
        post_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/can_fdm_route.sv
module can_fdm_route (
  input  logic hit_i,
  input  logic first_dom_i,
  input  logic role_tx_i,
  output logic tx_pen_o,
  output logic rx_pen_o,
  output logic rx_first_dom_o
);
  assign tx_pen_o       = hit_i && role_tx_i;
  assign rx_pen_o       = hit_i && !role_tx_i;
  assign rx_first_dom_o = first_dom_i && !role_tx_i;
endmodule

// File: rtl/can_flag_dom_monitor.sv
module can_flag_dom_monitor #(
  parameter int unsigned ACT_LIMIT = 14,
  parameter int unsigned PAS_LIMIT = 8,
  parameter int unsigned REPEAT    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_stb_i,
  input  logic       bus_dom_i,
  input  logic       flag_end_i,
  input  logic [1:0] flag_kind_i,
  input  logic       role_tx_i,
  output logic       tx_pen_o,
  output logic       rx_pen_o,
  output logic       rx_first_dom_o
);
  import can_fdm_pkg::*;

  localparam int unsigned MAX_A   = (ACT_LIMIT > PAS_LIMIT) ? ACT_LIMIT : PAS_LIMIT;
  localparam int unsigned MAX_LIM = (MAX_A > REPEAT) ? MAX_A : REPEAT;
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

  logic step, first_dom, hit, is_passive;

  assign is_passive = (flag_kind_e'(flag_kind_i) == FK_PASSIVE);

  can_fdm_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (flag_end_i),
    .bit_stb_i  (bit_stb_i),
    .bus_dom_i  (bus_dom_i),
    .step_o     (step),
    .first_dom_o(first_dom)
  );

  can_fdm_run_ctr #(
    .ACT_LIMIT(ACT_LIMIT),
    .PAS_LIMIT(PAS_LIMIT),
    .REPEAT   (REPEAT),
    .CNT_W    (CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (flag_end_i),
    .passive_i(is_passive),
    .step_i   (step),
    .hit_o    (hit)
  );

  can_fdm_route u_route (
    .hit_i         (hit),
    .first_dom_i   (first_dom),
    .role_tx_i     (role_tx_i),
    .tx_pen_o      (tx_pen_o),
    .rx_pen_o      (rx_pen_o),
    .rx_first_dom_o(rx_first_dom_o)
  );
endmodule

// File: rtl/can_fdm_chk.sv
module can_fdm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_stb_i,
  input logic bus_dom_i,
  input logic flag_end_i,
  input logic role_tx_i,
  input logic tx_pen_o,
  input logic rx_pen_o,
  input logic rx_first_dom_o
);
  logic any_out;
  assign any_out = tx_pen_o || rx_pen_o || rx_first_dom_o;

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!any_out); // R1
  end

  AST_PEN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_pen_o && rx_pen_o)); // R5
  AST_TX_ROLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pen_o |-> role_tx_i); // R5
  AST_RX_ROLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pen_o || rx_first_dom_o) |-> !role_tx_i); // R6
  AST_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_out |-> bit_stb_i); // R8
  AST_ON_DOMINANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_out |-> bus_dom_i); // R2
  AST_FLAG_END_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_end_i |-> !any_out); // R9
  AST_RECESSIVE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !bus_dom_i && !flag_end_i) |=> !any_out); // R7
  AST_FIRST_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_first_dom_o && !flag_end_i) |=> !rx_first_dom_o); // R6
endmodule

bind can_flag_dom_monitor can_fdm_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bit_stb_i     (bit_stb_i),
  .bus_dom_i     (bus_dom_i),
  .flag_end_i    (flag_end_i),
  .role_tx_i     (role_tx_i),
  .tx_pen_o      (tx_pen_o),
  .rx_pen_o      (rx_pen_o),
  .rx_first_dom_o(rx_first_dom_o)
);

// File: tb/can_flag_dom_monitor_tb_top.sv
`timescale 1ns/1ps
module can_flag_dom_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, dom = 1'b0, fe = 1'b0, role = 1'b0;
  logic [1:0] kind = 2'b00;
  logic       tx_pen, rx_pen, rx_first;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model state
  bit m_arm = 1'b0;
  int m_n   = 0;
  int m_thr = 14;

  always #2 clk = ~clk;

  can_flag_dom_monitor dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bit_stb_i     (stb),
    .bus_dom_i     (dom),
    .flag_end_i    (fe),
    .flag_kind_i   (kind),
    .role_tx_i     (role),
    .tx_pen_o      (tx_pen),
    .rx_pen_o      (rx_pen),
    .rx_first_dom_o(rx_first)
  );

  function automatic int thr_of(input logic [1:0] k);
    return (k == 2'b01) ? 8 : 14;
  endfunction

  function automatic bit pen_due(input int n, input int t);
    return (n >= t) && (((n - t) % 8) == 0);
  endfunction

  task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {tx,rx,first} actual=%b expected=%b (n=%0d thr=%0d)",
               req, act, exp, m_n, m_thr);
    end
  endtask

  task automatic cyc(input logic s, input logic d, input logic f,
                     input logic [1:0] k, input logic r);
    logic et, er, ef;
    string req;
    @(negedge clk);
    stb = s; dom = d; fe = f; kind = k; role = r;
    #1;
    et = 1'b0; er = 1'b0; ef = 1'b0;
    if (f) begin
      req = "R9";
      m_arm = 1'b1; m_n = 0; m_thr = thr_of(k);
    end else if (!s) begin
      req = "R8";
    end else if (!m_arm) begin
      req = "R7";
    end else if (!d) begin
      req = "R7";
      m_arm = 1'b0;
    end else begin
      m_n++;
      et = pen_due(m_n, m_thr) && r;
      er = pen_due(m_n, m_thr) && !r;
      ef = (m_n == 1) && !r;
      if (m_n == 1)             req = "R6";
      else if (m_n > m_thr)     req = "R4";
      else if (m_thr == 8)      req = "R3";
      else                      req = "R2";
      if (et || er) req = {req, "/R5"};
    end
    check3(req, {tx_pen, rx_pen, rx_first}, {et, er, ef});
  endtask

  task automatic idle_all();
    @(negedge clk);
    stb = 1'b0; dom = 1'b0; fe = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1'b1;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C4A));
    // R1: reset quiet with busy inputs
    stb = 1'b1; dom = 1'b1; fe = 1'b1;
    repeat (3) @(negedge clk);
    check3("R1", {tx_pen, rx_pen, rx_first}, 3'b000);
    stb = 1'b0; fe = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check3("R1", {tx_pen, rx_pen, rx_first}, 3'b000);
    // R1: dominant bits before any flag end
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);

    // R2/R4: active flag, transmitter, 30 dominant bits
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 1'b1);
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b1); // R7

    // R3/R4/R6: passive flag, receiver, 25 dominant bits
    cyc(1'b0, 1'b0, 1'b1, 2'b01, 1'b0);
    for (int i = 0; i < 25; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 1'b0);

    // R2: overload and reserved kinds, receiver
    cyc(1'b0, 1'b0, 1'b1, 2'b10, 1'b0);
    for (int i = 0; i < 15; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 2'b11, 1'b0);
    for (int i = 0; i < 15; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);

    // R9: flag end with strobe in the same cycle, mid-run restart
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 1'b1);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 2'b01, 1'b0);
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 1'b0);

    // R6: transmitter dominant first bit gets no first-bit request
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 2'b00, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 1'b1);

    // random episodes
    for (int ep = 0; ep < 400; ep++) begin
      logic [1:0] k;
      logic r;
      int len;
      k = 2'($urandom % 4);
      r = 1'($urandom % 2);
      len = int'($urandom % 40);
      cyc(1'($urandom % 2), 1'($urandom % 2), 1'b1, k, r);
      for (int b = 0; b < len; b++) begin
        if (($urandom % 4) == 0)
          cyc(1'b0, 1'($urandom % 2), 1'b0, 2'($urandom % 4), 1'($urandom % 2)); // R8
        if (($urandom % 10) == 0) r = ~r; // R5
        cyc(1'b1, 1'b1, 1'b0, 2'($urandom % 4), r);
      end
      if (($urandom % 8) != 0) begin
        cyc(1'b1, 1'b0, 1'b0, 2'b00, r);
        for (int t = 0; t < int'($urandom % 4); t++) cyc(1'b1, 1'b1, 1'b0, 2'b00, r); // R7
      end
    end
    idle_all();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule